// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Framing Recovery

This block turns an asynchronous serial line into characters. A one-cycle enable, pulsed at sixteen times the bit rate, paces every sample. The block looks for a falling edge on the idle-high line and confirms the start bit at its midpoint. It then takes one sample from the middle of each later bit period. Two character formats are supported. The first has five to eight data bits followed by an optional parity bit. The second has nine data bits and no parity.

Each completed character gives a single-cycle write strobe, a nine-bit data word and three tags: parity error, framing error and break. These are meant to be written side by side into a receive queue that sits outside this block.

Two recovery paths are built in. When the stop bit samples low and the character is not all zeros, the receiver writes the character with its framing tag. It then treats that low sample as the midpoint of the next start bit and goes straight on to data bits. When every sample from the start bit through the stop bit is low, the receiver writes one all-zero break character and then ignores the line until it has gone high again.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset `wr_stb`, `wr_data`, `err_par`, `err_frm` and `err_brk` are all 0.
- R2: A low level on `rx_in` that has gone high again by the 8th oversample tick of the start bit produces no character, and the receiver goes back to waiting for a start edge.
- R3: Data bits arrive least significant bit first. `data_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `wr_data` above the selected length are 0.
- R4: `par_mode` codes are: 0 none, 1 odd, 2 even, 3 always 1, 4 always 0 (codes 5 to 7 behave as none). With parity enabled, `err_par` is 1 exactly when the received parity bit differs from the expected value. Odd parity makes the total count of ones, including the parity bit, odd.
- R5: When `nine_bit_mode` is 1, nine data bits are received with the 9th bit in `wr_data[8]`. No parity bit is expected, whatever `par_mode` holds, and `err_par` stays 0.
- R6: A stop bit sampled low sets `err_frm` on that character, and `wr_data` holds the data bits as they were received.
- R7: After a framing error on a character that is not a break, the low stop sample is taken as the midpoint of the next start bit, and the next data bit is sampled one bit period later.
- R8: If the line is low at every sample from the start bit through the first stop bit, exactly one character is written with `wr_data` = 0, `err_brk` = 1, `err_frm` = 0 and `err_par` = 0.
- R9: After a break character no further character is written until `rx_in` has been seen high. After that, reception continues as normal.
- R10: `wr_stb` is high for exactly one clock cycle per character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_en | input | 1 | Oversample enable, one pulse per 1/16 bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| nine_bit_mode | input | 1 | 1 selects nine data bits with no parity |
| data_len | input | 2 | Data bit count minus 5 (used when nine_bit_mode is 0) |
| par_mode | input | 3 | Parity setting code |
| wr_stb | output | 1 | One-cycle strobe for a completed character |
| wr_data | output | 9 | Received character, right aligned |
| err_par | output | 1 | Parity error tag |
| err_frm | output | 1 | Framing error tag |
| err_brk | output | 1 | Break tag |

## Verification
Clean frames are sent in each data length and in nine-bit mode. These show that bits are placed LSB first and that every enabled format counts the right number of bits; a data value that reads differently when shifted exposes an off-by-one. Parity frames are sent with both correct and wrong parity bits under odd, even, forced-one and forced-zero settings, so that a swapped odd/even rule or an inverted forced value shows up as a wrong tag. Three line patterns separate the error paths: a short low glitch, which must produce nothing; a frame whose low stop bit runs straight into the next character, which must produce two characters with the second decoded correctly; and a long low level, which must produce exactly one break character and nothing more until the line goes high.

// File: rtl/urx_pkg.sv
package urx_pkg;

   localparam int MAXW = 9;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0,
      PAR_ODD  = 3'd1,
      PAR_EVEN = 3'd2,
      PAR_ONE  = 3'd3,
      PAR_ZERO = 3'd4
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKW
   } rx_state_e;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[0] <= 1'b1;
               else        sr[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[g] <= 1'b1;
               else        sr[g] <= sr[g-1];
            end
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/urx_parity.sv
module urx_parity
   import urx_pkg::*;
(
   input  logic [MAXW-1:0] data,
   input  par_mode_e       mode,
   output logic            exp_bit
);
   logic red;
   assign red = ^data;

   always_comb begin
      unique case (mode)
         PAR_ODD:  exp_bit = ~red;
         PAR_EVEN: exp_bit = red;
         PAR_ONE:  exp_bit = 1'b1;
         default:  exp_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/urx_core.sv
module urx_core
   import urx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            os_en,
   input  logic            rx,
   input  logic            nine_bit,
   input  logic [1:0]      data_len,
   input  par_mode_e       pmode,
   input  logic            par_exp,
   output logic [MAXW-1:0] shreg_o,
   output logic            wr_stb,
   output logic [MAXW-1:0] wr_data,
   output logic            err_par,
   output logic            err_frm,
   output logic            err_brk
);
   localparam int          CW      = $clog2(OVS);
   localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST    = CW'(OVS - 1);

   rx_state_e       st;
   logic [CW-1:0]   cnt;
   logic [3:0]      bidx;
   logic [MAXW-1:0] shreg;
   logic            allz;
   logic            par_bit;

   logic [3:0] last_idx;
   logic       par_en;
   logic       par_bad;

   assign last_idx = nine_bit ? 4'd8 : ({2'b00, data_len} + 4'd4);
   assign par_en   = !nine_bit &&
                     (pmode == PAR_ODD || pmode == PAR_EVEN ||
                      pmode == PAR_ONE || pmode == PAR_ZERO);
   assign par_bad  = par_en && (par_bit != par_exp);
   assign shreg_o  = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         shreg   <= '0;
         allz    <= 1'b0;
         par_bit <= 1'b0;
         wr_stb  <= 1'b0;
         wr_data <= '0;
         err_par <= 1'b0;
         err_frm <= 1'b0;
         err_brk <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (os_en) begin
            unique case (st)
               ST_IDLE: begin
                  if (!rx) begin
                     st  <= ST_START;
                     cnt <= CW'(1);
                  end
               end
               ST_START: begin
                  if (cnt == HALF_M1) begin
                     cnt <= '0;
                     if (!rx) begin
                        st      <= ST_DATA;
                        bidx    <= '0;
                        shreg   <= '0;
                        allz    <= 1'b1;
                        par_bit <= 1'b0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA, ST_PAR, ST_STOP: begin
                  if (cnt != LAST) begin
                     cnt <= cnt + 1'b1;
                  end else begin
                     cnt <= '0;
                     if (st == ST_DATA) begin
                        shreg[bidx] <= rx;
                        allz        <= allz & !rx;
                        if (bidx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
                        else                  bidx <= bidx + 1'b1;
                     end else if (st == ST_PAR) begin
                        par_bit <= rx;
                        allz    <= allz & !rx;
                        st      <= ST_STOP;
                     end else begin
                        wr_stb <= 1'b1;
                        if (rx) begin
                           wr_data <= shreg;
                           err_par <= par_bad;
                           err_frm <= 1'b0;
                           err_brk <= 1'b0;
                           st      <= ST_IDLE;
                        end else if (allz) begin
                           wr_data <= '0;
                           err_par <= 1'b0;
                           err_frm <= 1'b0;
                           err_brk <= 1'b1;
                           st      <= ST_BRKW;
                        end else begin
                           wr_data <= shreg;
                           err_par <= par_bad;
                           err_frm <= 1'b1;
                           err_brk <= 1'b0;
                           st      <= ST_DATA;
                           bidx    <= '0;
                           shreg   <= '0;
                           allz    <= 1'b1;
                           par_bit <= 1'b0;
                        end
                     end
                  end
               end
               ST_BRKW: begin
                  if (rx) st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
   import urx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            os_en,
   input  logic            rx_in,
   input  logic            nine_bit_mode,
   input  logic [1:0]      data_len,
   input  logic [2:0]      par_mode,
   output logic            wr_stb,
   output logic [MAXW-1:0] wr_data,
   output logic            err_par,
   output logic            err_frm,
   output logic            err_brk
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_brk_rx: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_brk_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic            rx_s;
   logic            par_exp;
   logic [MAXW-1:0] shreg;
   par_mode_e       pmode;

   assign pmode = par_mode_e'(par_mode);

   urx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   urx_parity par_i (
      .data    (shreg),
      .mode    (pmode),
      .exp_bit (par_exp)
   );

   urx_core #(.OVS(OVS)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_en    (os_en),
      .rx       (rx_s),
      .nine_bit (nine_bit_mode),
      .data_len (data_len),
      .pmode    (pmode),
      .par_exp  (par_exp),
      .shreg_o  (shreg),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data),
      .err_par  (err_par),
      .err_frm  (err_frm),
      .err_brk  (err_brk)
   );
endmodule

// File: rtl/urx_chk.sv
module urx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_in,
   input logic       nine_bit_mode,
   input logic       wr_stb,
   input logic [8:0] wr_data,
   input logic       err_par,
   input logic       err_frm,
   input logic       err_brk
);
   logic brk_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 brk_hold <= 1'b0;
      else if (rx_in)             brk_hold <= 1'b0;
      else if (wr_stb && err_brk) brk_hold <= 1'b1;
   end

   // R10
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R8
   brk_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && err_brk) |-> (wr_data == 9'd0 && !err_frm && !err_par));

   // R5
   nine_nopar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && nine_bit_mode) |-> !err_par);

   // R3
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !nine_bit_mode) |-> !wr_data[8]);

   // R9
   brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hold |-> !wr_stb);
endmodule

bind uart_brk_rx urx_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_in         (rx_in),
   .nine_bit_mode (nine_bit_mode),
   .wr_stb        (wr_stb),
   .wr_data       (wr_data),
   .err_par       (err_par),
   .err_frm       (err_frm),
   .err_brk       (err_brk)
);

// File: tb/uart_brk_rx_tb_top.sv
module uart_brk_rx_tb_top;
   localparam int BITCLK = 32;

   typedef struct {
      logic [8:0] data;
      logic       par;
      logic       frm;
      logic       brk;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_en = 1'b0;
   logic       rx_in = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic [1:0] data_len = 2'd3;
   logic [2:0] par_mode = 3'd0;
   logic       wr_stb;
   logic [8:0] wr_data;
   logic       err_par, err_frm, err_brk;

   int    n_chk = 0;
   int    n_fail = 0;
   int    stb_cnt = 0;
   logic  prev_stb = 1'b0;
   item_t q[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) os_en <= rst_n ? ~os_en : 1'b0;

   uart_brk_rx dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .os_en         (os_en),
      .rx_in         (rx_in),
      .nine_bit_mode (nine_bit_mode),
      .data_len      (data_len),
      .par_mode      (par_mode),
      .wr_stb        (wr_stb),
      .wr_data       (wr_data),
      .err_par       (err_par),
      .err_frm       (err_frm),
      .err_brk       (err_brk)
   );

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stb) begin
            n_chk++;
            if (wr_stb) begin
               n_fail++;
               $display("FAIL R10 strobe width: actual 2+ cycles expected 1");
            end
         end
         prev_stb = wr_stb;
         if (wr_stb) begin
            stb_cnt++;
            n_chk++;
            if (q.size() == 0) begin
               n_fail++;
               $display("FAIL unexpected character: actual data=%h par=%b frm=%b brk=%b expected none",
                        wr_data, err_par, err_frm, err_brk);
            end else begin
               item_t e;
               e = q.pop_front();
               if (wr_data !== e.data || err_par !== e.par ||
                   err_frm !== e.frm || err_brk !== e.brk) begin
                  n_fail++;
                  $display("FAIL %s: actual data=%h par=%b frm=%b brk=%b expected data=%h par=%b frm=%b brk=%b",
                           e.req, wr_data, err_par, err_frm, err_brk,
                           e.data, e.par, e.frm, e.brk);
               end
            end
         end
      end
   end

   task automatic expect_item(input logic [8:0] d, input logic p,
                              input logic f, input logic b, input string r);
      item_t e;
      e.data = d; e.par = p; e.frm = f; e.brk = b; e.req = r;
      q.push_back(e);
   endtask

   task automatic drive_bit(input logic v);
      rx_in = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic idle(input int nbits);
      for (int i = 0; i < nbits; i++) drive_bit(1'b1);
   endtask

   function automatic logic par_of(input logic [8:0] d, input logic [2:0] m);
      case (m)
         3'd1:    return ~(^d);
         3'd2:    return ^d;
         3'd3:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // start, nb data bits LSB first, optional parity, one stop
   task automatic frame(input logic [8:0] d, input int nb, input logic has_p,
                        input logic pbit, input logic stopv);
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (has_p) drive_bit(pbit);
      drive_bit(stopv);
   endtask

   task automatic check_count(input int want, input string r);
      n_chk++;
      if (stb_cnt != want) begin
         n_fail++;
         $display("FAIL %s character count: actual %0d expected %0d", r, stb_cnt, want);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (wr_stb !== 1'b0 || wr_data !== 9'd0 || err_par !== 1'b0 ||
          err_frm !== 1'b0 || err_brk !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: actual stb=%b data=%h tags=%b%b%b expected all 0",
                  wr_stb, wr_data, err_par, err_frm, err_brk);
      end
      idle(2);

      // R3: 8 bits, no parity
      data_len = 2'd3; par_mode = 3'd0;
      expect_item(9'h0A5, 1'b0, 1'b0, 1'b0, "R3 8-bit");
      frame(9'h0A5, 8, 1'b0, 1'b0, 1'b1); idle(2);
      // R3: 5 bits
      data_len = 2'd0;
      expect_item(9'h016, 1'b0, 1'b0, 1'b0, "R3 5-bit");
      frame(9'h016, 5, 1'b0, 1'b0, 1'b1); idle(2);
      // R3: 6 bits
      data_len = 2'd1;
      expect_item(9'h02D, 1'b0, 1'b0, 1'b0, "R3 6-bit");
      frame(9'h02D, 6, 1'b0, 1'b0, 1'b1); idle(2);

      // R4: 7 bits, even parity correct
      data_len = 2'd2; par_mode = 3'd2;
      expect_item(9'h035, 1'b0, 1'b0, 1'b0, "R4 even ok");
      frame(9'h035, 7, 1'b1, par_of(9'h035, 3'd2), 1'b1); idle(2);
      // R4: odd parity wrong bit
      par_mode = 3'd1;
      expect_item(9'h035, 1'b1, 1'b0, 1'b0, "R4 odd bad");
      frame(9'h035, 7, 1'b1, ~par_of(9'h035, 3'd1), 1'b1); idle(2);
      // R4: odd parity correct, 8 bits
      data_len = 2'd3;
      expect_item(9'h0C3, 1'b0, 1'b0, 1'b0, "R4 odd ok");
      frame(9'h0C3, 8, 1'b1, par_of(9'h0C3, 3'd1), 1'b1); idle(2);
      // R4: forced one correct, forced zero wrong
      par_mode = 3'd3;
      expect_item(9'h012, 1'b0, 1'b0, 1'b0, "R4 one ok");
      frame(9'h012, 8, 1'b1, 1'b1, 1'b1); idle(2);
      par_mode = 3'd4;
      expect_item(9'h012, 1'b1, 1'b0, 1'b0, "R4 zero bad");
      frame(9'h012, 8, 1'b1, 1'b1, 1'b1); idle(2);

      // R5: nine bits, parity setting ignored
      nine_bit_mode = 1'b1; par_mode = 3'd1;
      expect_item(9'h1A3, 1'b0, 1'b0, 1'b0, "R5 nine-bit");
      frame(9'h1A3, 9, 1'b0, 1'b0, 1'b1); idle(2);
      nine_bit_mode = 1'b0; par_mode = 3'd0;

      // R2: short glitch
      base = stb_cnt;
      rx_in = 1'b0;
      repeat (8) @(negedge clk);
      idle(3);
      check_count(base, "R2 glitch");

      // R6 + R7: low stop bit runs into next character
      expect_item(9'h03C, 1'b0, 1'b1, 1'b0, "R6 framing");
      expect_item(9'h081, 1'b0, 1'b0, 1'b0, "R7 resync");
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(((9'h03C >> i) & 9'h1) != 0);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(((9'h081 >> i) & 9'h1) != 0);
      drive_bit(1'b1);
      idle(2);

      // R8 + R9: break
      expect_item(9'h000, 1'b0, 1'b0, 1'b1, "R8 break");
      base = stb_cnt;
      for (int i = 0; i < 22; i++) drive_bit(1'b0);
      check_count(base + 1, "R9 held low");
      idle(2);
      expect_item(9'h05A, 1'b0, 1'b0, 1'b0, "R9 resume");
      frame(9'h05A, 8, 1'b0, 1'b0, 1'b1); idle(2);

      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R3 pending items: actual %0d expected 0", q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule